// File: doc/BRIEF.md
# Synchronous Burst Cache Data RAM

A clocked single-port data store meant to sit behind a processor as the data half of a secondary cache. Each word is split into byte lanes (two lanes of nine bits by default), and each lane has its own active-low write enable. The address is registered at the rising clock edge. A two-bit burst counter supplies the low address bits for the second, third and fourth accesses of a burst of four, so the processor presents only the first address.

A burst opens on either of two active-low strobes. The processor strobe counts only while chip select is active, and the cycle it opens is always a read. The controller strobe opens a read or a write, depending on the lane enables in the same cycle. A controller strobe with chip select inactive deselects the block. Once a burst is open, an active-low advance input steps the counter and a high advance repeats the current address. Any cycle of an open burst writes when a lane enable is low. A parameter chooses the burst order: interleaved (start offset XOR count) or linear (start offset plus count, modulo four). Read data is registered and leaves on a shared tri-state bus under an asynchronous output enable.

Top module: `burst_sram`

## Requirements
- R1: After reset the block does not drive the data bus until a read cycle has been clocked.
- R2: A controller strobe (adsc_n low, adsp_n high) with cs_n low and any we_n bit low writes the bus value at the presented address. we_n[1] guards bits 17:9 and we_n[0] guards bits 8:0. The block does not drive the bus in the following cycle.
- R3: A controller strobe with cs_n low and both we_n bits high reads the presented address. The data is on the bus during the cycle after that clock edge.
- R4: A processor strobe (adsp_n low) with cs_n low loads the address and reads it, whatever the values of we_n and adv_n in that cycle.
- R5: A processor strobe sampled while cs_n is high is ignored. The cycle behaves as though adsp_n were high.
- R6: In interleaved mode (LINEAR=0), each cycle of an open burst with adv_n low and no strobe accesses the low address bits start XOR count. The count rises by one and wraps after 3.
- R7: In linear mode (LINEAR=1), the same advance accesses the low bits (start + count) mod 4. The upper address bits stay fixed.
- R8: adv_n low has no effect in a cycle where a strobe is accepted. The count restarts at zero at the strobed address.
- R9: With adv_n high and no strobe, an open burst accesses the same address again. It writes there if any we_n bit is low and reads otherwise. This is how the cycle after a processor strobe performs a write.
- R10: A controller strobe with cs_n high deselects the block. Advance, write and read requests then have no effect until a new strobe is accepted.
- R11: The bus is undriven whenever oe_n is high or any we_n bit is low, and oe_n acts without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Synchronous chip select, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| addr | input | ADDR_W | Word address |
| we_n | input | LANES | Per-lane write enables, active low (bit 1 = high lane) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | inout | LANES*LANE_W | Bidirectional data bus |

## Verification
The bench builds two copies with a six-bit address (64 words), two nine-bit lanes, and one instance of each burst order. The same stimulus drives both copies. A small depth lets the bench write every word at the start, so every later read has a known value, and random bursts reach all four start offsets and the counter wrap often. Comparing the two orders on identical traffic shows that only the low two address bits differ between the modes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } mem_op_e;

   localparam int unsigned BURST_LEN = 4;
   localparam int unsigned OFS_W     = 2;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
   parameter bit LINEAR = 1'b0
) (
   input  logic [1:0] start_ofs,
   input  logic [1:0] count,
   output logic [1:0] ofs
);
   generate
      if (LINEAR) begin : g_linear
         always_comb ofs = start_ofs + count;
      end else begin : g_interleave
         always_comb ofs = start_ofs ^ count;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_ctl.sv
module burst_addr_ctl
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter bit          LINEAR = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              adv_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we_any,
   output logic [ADDR_W-1:0] eff_addr,
   output mem_op_e           op,
   output logic              sel_q,
   output logic [1:0]        cnt_q
);
   localparam int unsigned HI_W = ADDR_W - OFS_W;

   logic [HI_W-1:0] base_q;
   logic [1:0]      start_q;
   logic            p_start, c_any, c_load, c_desel, no_strobe, stepping;
   logic [1:0]      cnt_nxt;
   logic [1:0]      ofs;

   always_comb begin
      p_start   = !adsp_n && !cs_n;
      c_any     = !p_start && !adsc_n;
      c_load    = c_any && !cs_n;
      c_desel   = c_any && cs_n;
      no_strobe = !p_start && adsc_n;
      stepping  = no_strobe && sel_q && !adv_n;
      cnt_nxt   = stepping ? cnt_q + 2'd1 : cnt_q;
   end

   burst_seq #(.LINEAR(LINEAR)) u_seq (
      .start_ofs (start_q),
      .count     (cnt_nxt),
      .ofs       (ofs)
   );

   always_comb begin
      if (p_start || c_load) eff_addr = addr;
      else                   eff_addr = {base_q, ofs};
      if (p_start)                op = OP_READ;
      else if (c_load)            op = we_any ? OP_WRITE : OP_READ;
      else if (no_strobe && sel_q) op = we_any ? OP_WRITE : OP_READ;
      else                        op = OP_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         sel_q   <= 1'b0;
      end else if (p_start || c_load) begin
         base_q  <= addr[ADDR_W-1:OFS_W];
         start_q <= addr[OFS_W-1:0];
         cnt_q   <= '0;
         sel_q   <= 1'b1;
      end else if (c_desel) begin
         sel_q   <= 1'b0;
      end else if (stepping) begin
         cnt_q   <= cnt_nxt;
      end
   end
endmodule

// File: rtl/burst_lane_mem.sv
module burst_lane_mem #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wdata,
   output logic [LANE_W-1:0] rdata_q
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (rd_en) rdata_q <= mem[addr];
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 2,
   parameter int unsigned LANE_W = 9,
   parameter bit          LINEAR = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    adsp_n,
   input  logic                    adsc_n,
   input  logic                    adv_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES-1:0]        we_n,
   input  logic                    oe_n,
   inout  wire  [LANES*LANE_W-1:0] dq
);
   localparam int unsigned DATA_W = LANES * LANE_W;

   generate
      if (ADDR_W < OFS_W + 1) begin : g_bad_addr
         $error("burst_sram: ADDR_W must exceed the burst offset width");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram: LANES and LANE_W must be positive");
      end
   endgenerate

   mem_op_e           op;
   logic [ADDR_W-1:0] eff_addr;
   logic              sel_q;
   logic [1:0]        cnt_q;
   logic              drv_q;
   logic              bus_en;
   logic              we_any;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] wr_word;

   always_comb we_any = !(&we_n);
   always_comb wr_word = dq;

   burst_addr_ctl #(.ADDR_W(ADDR_W), .LINEAR(LINEAR)) u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n     (cs_n),
      .adsp_n   (adsp_n),
      .adsc_n   (adsc_n),
      .adv_n    (adv_n),
      .addr     (addr),
      .we_any   (we_any),
      .eff_addr (eff_addr),
      .op       (op),
      .sel_q    (sel_q),
      .cnt_q    (cnt_q)
   );

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         burst_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_mem (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   ((op == OP_WRITE) && !we_n[l]),
            .rd_en   (op == OP_READ),
            .addr    (eff_addr),
            .wdata   (wr_word[l*LANE_W +: LANE_W]),
            .rdata_q (rd_word[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_q <= 1'b0;
      else        drv_q <= (op == OP_READ);
   end

   always_comb bus_en = drv_q && !oe_n && !we_any;
   assign dq = bus_en ? rd_word : {DATA_W{1'bz}};
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       adsp_n,
   input logic       adsc_n,
   input logic       adv_n,
   input logic       we_all_hi,
   input logic       sel_q,
   input logic [1:0] cnt_q,
   input logic       drv_q
);
   // R4
   pstart_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adsp_n && !cs_n) |=> (drv_q && sel_q && cnt_q == 2'd0));

   // R2
   cwrite_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adsp_n && !adsc_n && !cs_n && !we_all_hi) |=> !drv_q);

   // R10
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((adsp_n || cs_n) && !adsc_n && cs_n) |=> (!sel_q && !drv_q));

   // R8
   adv_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_n && !cs_n && (!adsp_n || !adsc_n)) |=> cnt_q == 2'd0);

   // R9
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((adsp_n || cs_n) && adsc_n && adv_n) |=> ($stable(cnt_q) && $stable(sel_q)));

   // R6
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q && (adsp_n || cs_n) && adsc_n && !adv_n) |=> cnt_q == $past(cnt_q) + 2'd1);
endmodule

bind burst_sram burst_sram_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .adsp_n    (adsp_n),
   .adsc_n    (adsc_n),
   .adv_n     (adv_n),
   .we_all_hi (&we_n),
   .sel_q     (sel_q),
   .cnt_q     (cnt_q),
   .drv_q     (drv_q)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
   localparam int AW = 6;
   localparam int DW = 18;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [1:0]    we_n = 2'b11;
   logic          tb_en = 1'b1;
   logic [DW-1:0] tb_val = '0;
   wire  [DW-1:0] dq_i, dq_l;

   assign dq_i = tb_en ? tb_val : {DW{1'bz}};
   assign dq_l = tb_en ? tb_val : {DW{1'bz}};

   always #5 clk = ~clk;

   burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9), .LINEAR(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
      .adv_n(adv_n), .addr(addr), .we_n(we_n), .oe_n(oe_n), .dq(dq_i));

   burst_sram #(.ADDR_W(AW), .LANES(2), .LANE_W(9), .LINEAR(1'b1)) dut_lin (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
      .adv_n(adv_n), .addr(addr), .we_n(we_n), .oe_n(oe_n), .dq(dq_l));

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // reference state, index 0 = interleaved, 1 = linear
   logic [DW-1:0] mdl_mem [2][DEPTH];
   logic [AW-1:0] m_base [2];
   logic [1:0]    m_start [2];
   logic [1:0]    m_cnt [2];
   bit            m_sel [2];
   bit            m_drv;
   logic [DW-1:0] m_rd [2];
   string         m_tag [2];

   function automatic logic [1:0] seq_ofs(input logic [1:0] st, input logic [1:0] c, input int m);
      return (m == 1) ? st + c : st ^ c;
   endfunction

   function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
      return {3'b101, a, 3'b010, a} ^ DW'(a * 37);
   endfunction

   task automatic model_edge();
      bit p, c;
      p = !adsp_n && !cs_n;
      c = !p && !adsc_n;
      for (int m = 0; m < 2; m++) begin
         logic [AW-1:0] ea;
         int op; // 0 idle 1 read 2 write
         op = 0;
         ea = '0;
         if (p) begin
            ea = addr; m_base[m] = addr; m_start[m] = addr[1:0]; m_cnt[m] = 0;
            m_sel[m] = 1'b1; op = 1;
            m_tag[m] = !adv_n ? "R8" : "R4";
         end else if (c && cs_n) begin
            m_sel[m] = 1'b0; op = 0; m_tag[m] = "R10";
         end else if (c) begin
            ea = addr; m_base[m] = addr; m_start[m] = addr[1:0]; m_cnt[m] = 0;
            m_sel[m] = 1'b1; op = (we_n != 2'b11) ? 2 : 1;
            m_tag[m] = (op == 2) ? "R2" : (!adv_n ? "R8" : "R3");
         end else if (m_sel[m]) begin
            if (!adv_n) begin
               m_cnt[m] = m_cnt[m] + 2'd1;
               m_tag[m] = (m == 1) ? "R7" : "R6";
            end else begin
               m_tag[m] = "R9";
            end
            ea = {m_base[m][AW-1:2], seq_ofs(m_start[m], m_cnt[m], m)};
            op = (we_n != 2'b11) ? 2 : 1;
         end else begin
            m_tag[m] = "R10";
         end
         if (!adsp_n && cs_n) m_tag[m] = "R5";
         if (op == 1) m_rd[m] = mdl_mem[m][ea];
         if (op == 2) begin
            if (!we_n[1]) mdl_mem[m][ea][17:9] = tb_val[17:9];
            if (!we_n[0]) mdl_mem[m][ea][8:0]  = tb_val[8:0];
         end
         if (m == 1) m_drv = (op == 1);
      end
   endtask

   task automatic check_bus();
      bit exp_on;
      exp_on = m_drv && !oe_n && (we_n == 2'b11);
      for (int m = 0; m < 2; m++) begin
         logic [DW-1:0] got, exp;
         string tag;
         got = (m == 0) ? dq_i : dq_l;
         exp = exp_on ? m_rd[m] : tb_val;
         tag = m_tag[m];
         if (!exp_on && m_drv) tag = "R11";
         checks++;
         if (got !== exp) begin
            failures++;
            $display("FAIL %s dut%0d bus actual=%h expected=%h", tag, m, got, exp);
         end
      end
   endtask

   // apply one cycle: inputs held from now through the next rising edge
   task automatic cycle(input bit i_cs, input bit i_p, input bit i_c, input bit i_adv,
                        input logic [AW-1:0] i_a, input logic [1:0] i_we, input bit i_oe,
                        input logic [DW-1:0] i_d);
      cs_n = i_cs; adsp_n = i_p; adsc_n = i_c; adv_n = i_adv;
      addr = i_a; we_n = i_we; oe_n = i_oe;
      tb_en = !(m_drv && !i_oe && (i_we == 2'b11));
      tb_val = i_d;
      #1;
      check_bus();
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin
         m_sel[m] = 0; m_cnt[m] = 0; m_start[m] = 0; m_base[m] = 0; m_rd[m] = 0; m_tag[m] = "R1";
      end
      m_drv = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: bus idle after reset
      cycle(1, 1, 1, 1, 0, 2'b11, 0, 18'h2A5A5);
      // R2: fill memory through controller-strobe writes
      for (int a = 0; a < DEPTH; a++)
         cycle(0, 1, 0, 1, AW'(a), 2'b00, 0, pattern(AW'(a)));
      // R2: partial lane write, high lane only
      cycle(0, 1, 0, 1, 6'd5, 2'b01, 0, 18'h3FFFF);
      cycle(0, 1, 0, 1, 6'd5, 2'b11, 0, 18'h0);        // R3 read back
      // R6 R7: burst from offset 2 with four accesses
      cycle(0, 1, 0, 1, 6'd14, 2'b11, 0, 18'h0);
      for (int k = 0; k < 4; k++) cycle(1, 1, 1, 0, 6'd0, 2'b11, 0, 18'h0);
      // R4: processor strobe ignoring write enables, then R9 write after it
      cycle(0, 0, 1, 0, 6'd33, 2'b00, 0, 18'h1);
      cycle(1, 1, 1, 1, 6'd0, 2'b00, 0, 18'h15555);
      cycle(1, 1, 1, 1, 6'd0, 2'b11, 0, 18'h0);
      // R5: processor strobe with chip select inactive
      cycle(1, 0, 1, 0, 6'd60, 2'b11, 0, 18'h0);
      // R10: deselect, then advance and write requests
      cycle(1, 1, 0, 1, 6'd7, 2'b11, 0, 18'h0);
      cycle(1, 1, 1, 0, 6'd7, 2'b00, 0, 18'h12345);
      cycle(1, 1, 1, 0, 6'd7, 2'b11, 0, 18'h0);
      // R11: output enable high during a read
      cycle(0, 1, 0, 1, 6'd9, 2'b11, 0, 18'h0);
      cycle(1, 1, 1, 1, 6'd0, 2'b11, 1, 18'h0ABCD);
      // R8: advance together with a strobe
      cycle(0, 1, 0, 0, 6'd23, 2'b11, 0, 18'h0);
      cycle(1, 1, 1, 0, 6'd0, 2'b11, 0, 18'h0);
      // random traffic
      void'($urandom(32'd1234));
      for (int n = 0; n < 4000; n++) begin
         bit r_cs, r_p, r_c, r_adv, r_oe;
         logic [1:0] r_we;
         r_cs  = ($urandom % 100) < 12;
         r_p   = ($urandom % 100) >= 15;
         r_c   = ($urandom % 100) >= 15;
         r_adv = ($urandom % 100) >= 55;
         r_we  = (($urandom % 100) < 25) ? 2'($urandom % 3) : 2'b11;
         r_oe  = ($urandom % 100) < 10;
         cycle(r_cs, r_p, r_c, r_adv, AW'($urandom), r_we, r_oe, DW'($urandom));
      end
      cycle(1, 1, 1, 1, 6'd0, 2'b11, 0, 18'h0);
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule